// File: doc/BRIEF.md
# Ultra DMA Data-In Burst Launch Controller

This host-side controller opens an Ultra DMA data-in burst on a parallel disk interface. While idle it passes the host's register-access values for the ready line, the chip selects and the address lines straight to the pins. It keeps the acknowledge line negated and keeps driving the data bus. Once software enables a start and the synchronized device request is seen, the controller enters a setup cycle. In that cycle it raises STOP, negates the host ready line, and parks the selects and address lines in their negated state, all together. It then waits a programmable settling time before it asserts the acknowledge. A programmable number of cycles later it stops driving the data bus.

While the acknowledge is low, the controller holds it low. A burst ends in one of two ways: an explicit end command, or the device withdrawing its request after its strobe has fallen at least once. At the end, the controller first releases the acknowledge. One cycle later it hands the select and address lines back to their idle values. The burst-active flag marks exactly the cycles in which the acknowledge is asserted. The data transfer phase, pausing and CRC are handled elsewhere.

Top module: `udma_burst_launch`

## Requirements
- R1: After reset, or while idle, ack_n_o=1, stop_o=0, burst_active_o=0 and bus_drive_o=1. host_rdy_n_o, sel_n_o and addr_o equal idle_rdy_n_i, idle_sel_n_i and idle_addr_i in the same cycle.
- R2: A burst starts only while start_en_i=1 and the synchronized device request is high. A request that rises while start_en_i=1 shows stop_o=1 three clock edges later. A start enable given while the request is already synchronized shows stop_o=1 one edge later.
- R3: In the first cycle with stop_o=1, all of the following hold together: host_rdy_n_o=1, sel_n_o=all ones, addr_o=all zeros and ack_n_o=1.
- R4: ack_n_o falls exactly T_ACK cycles after stop_o rises, with T_ACK at least 2.
- R5: bus_drive_o stays 1 for the first min(BUS_REL, T_AZ) cycles of the acknowledge and is 0 from then on while the acknowledge is held.
- R6: While the acknowledge is asserted, it stays asserted unless the burst is ended. A drop of the device request before the first falling edge of the device strobe has no effect.
- R7: After a falling edge of the device strobe during an acknowledged burst, a drop of the device request ends the burst: ack_n_o rises three edges after the drop.
- R8: end_burst_i=1 during an acknowledged burst raises ack_n_o at the next edge. At that edge sel_n_o and addr_o are still negated. One edge later they return to the idle inputs and stop_o returns to 0.
- R9: end_burst_i has no effect while idle or before the acknowledge is asserted.
- R10: burst_active_o is 1 in exactly the cycles where ack_n_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_en_i | input | 1 | Permits a new burst to start |
| dev_req_i | input | 1 | Device DMA request (asynchronous) |
| dev_strobe_i | input | 1 | Device data strobe (asynchronous) |
| end_burst_i | input | 1 | Command to end the current burst |
| idle_rdy_n_i | input | 1 | Host ready value used while idle |
| idle_sel_n_i | input | SEL_W | Chip-select values used while idle |
| idle_addr_i | input | ADDR_W | Address values used while idle |
| stop_o | output | 1 | STOP line |
| host_rdy_n_o | output | 1 | Host ready line, active low |
| sel_n_o | output | SEL_W | Chip selects, active low |
| addr_o | output | ADDR_W | Register address lines |
| ack_n_o | output | 1 | DMA acknowledge, active low |
| bus_drive_o | output | 1 | Host drives the 16-bit data bus |
| burst_active_o | output | 1 | Burst in progress |

## Verification
The bench builds the block with T_ACK=3, BUS_REL=2 and T_AZ=3. With these values the settle count, the bus-release window and the end sequence all fit in a few cycles. The bench sweeps every idle select, address and ready combination. It ends bursts at every offset from the first acknowledge cycle to well past the bus release, so end commands land in both the release window and the steady burst. Separate runs cover an end command during setup, a start with the request already synchronized, and a request withdrawn before and after a strobe fall.

// File: rtl/udma_launch_pkg.sv
package udma_launch_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT_TACK,
        ST_ACKED,
        ST_BURST,
        ST_END
    } launch_state_e;
endpackage

// File: rtl/udma_sync2.sv
module udma_sync2 #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/udma_fall_det.sv
module udma_fall_det (
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= lvl_i;
    end

    assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/udma_launch_fsm.sv
module udma_launch_fsm
    import udma_launch_pkg::*;
#(
    parameter int ACK_CYC = 3,
    parameter int REL_CYC = 1,
    parameter int SEL_W   = 2,
    parameter int ADDR_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_en_i,
    input  logic              req_s_i,
    input  logic              strobe_fall_i,
    input  logic              end_burst_i,
    input  logic              idle_rdy_n_i,
    input  logic [SEL_W-1:0]  idle_sel_n_i,
    input  logic [ADDR_W-1:0] idle_addr_i,
    output logic              stop_o,
    output logic              host_rdy_n_o,
    output logic [SEL_W-1:0]  sel_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ack_n_o,
    output logic              bus_drive_o,
    output logic              burst_active_o
);
    localparam int MAX_CNT = (ACK_CYC > REL_CYC) ? ACK_CYC : REL_CYC;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    typedef struct packed {
        launch_state_e    state;
        logic [CNT_W-1:0] cnt;
        logic             hold;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic eff_req;
    logic acked;

    assign acked   = (cur_q.state == ST_ACKED) || (cur_q.state == ST_BURST);
    assign eff_req = req_s_i | cur_q.hold;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (start_en_i && req_s_i) begin
                    nxt_d.state = ST_SETUP;
                    nxt_d.hold  = 1'b1;
                    nxt_d.cnt   = '0;
                end
            end
            ST_SETUP: begin
                nxt_d.state = ST_WAIT_TACK;
                nxt_d.cnt   = CNT_W'(1);
            end
            ST_WAIT_TACK: begin
                if (cur_q.cnt == CNT_W'(ACK_CYC - 1)) begin
                    nxt_d.state = ST_ACKED;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_ACKED: begin
                if (end_burst_i) begin
                    nxt_d.state = ST_END;
                end else if (cur_q.cnt == CNT_W'(REL_CYC - 1)) begin
                    nxt_d.state = ST_BURST;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_BURST: begin
                if (end_burst_i || !eff_req) nxt_d.state = ST_END;
            end
            ST_END: begin
                nxt_d.state = ST_IDLE;
                nxt_d.hold  = 1'b0;
                nxt_d.cnt   = '0;
            end
            default: begin
                nxt_d.state = ST_IDLE;
                nxt_d.hold  = 1'b0;
                nxt_d.cnt   = '0;
            end
        endcase
        if (acked && strobe_fall_i) nxt_d.hold = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q.state <= ST_IDLE;
            cur_q.cnt   <= '0;
            cur_q.hold  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        if (cur_q.state == ST_IDLE) begin
            stop_o       = 1'b0;
            host_rdy_n_o = idle_rdy_n_i;
            sel_n_o      = idle_sel_n_i;
            addr_o       = idle_addr_i;
        end else begin
            stop_o       = 1'b1;
            host_rdy_n_o = 1'b1;
            sel_n_o      = '1;
            addr_o       = '0;
        end
        ack_n_o        = ~acked;
        burst_active_o = acked;
        bus_drive_o    = (cur_q.state != ST_BURST) && (cur_q.state != ST_END);
    end
endmodule

// File: rtl/udma_burst_launch.sv
module udma_burst_launch #(
    parameter int T_ACK   = 3,
    parameter int T_AZ    = 2,
    parameter int BUS_REL = 1,
    parameter int SEL_W   = 2,
    parameter int ADDR_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_en_i,
    input  logic              dev_req_i,
    input  logic              dev_strobe_i,
    input  logic              end_burst_i,
    input  logic              idle_rdy_n_i,
    input  logic [SEL_W-1:0]  idle_sel_n_i,
    input  logic [ADDR_W-1:0] idle_addr_i,
    output logic              stop_o,
    output logic              host_rdy_n_o,
    output logic [SEL_W-1:0]  sel_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ack_n_o,
    output logic              bus_drive_o,
    output logic              burst_active_o
);
    localparam int ACK_CYC = (T_ACK < 2) ? 2 : T_ACK;
    localparam int AZ_CYC  = (T_AZ < 1) ? 1 : T_AZ;
    localparam int REL_LIM = (BUS_REL < 1) ? 1 : BUS_REL;
    localparam int REL_CYC = (REL_LIM > AZ_CYC) ? AZ_CYC : REL_LIM;

    logic [1:0] raw_in;
    logic [1:0] sync_out;
    logic       req_s;
    logic       strobe_s;
    logic       strobe_fall;

    assign raw_in   = {dev_strobe_i, dev_req_i};
    assign req_s    = sync_out[0];
    assign strobe_s = sync_out[1];

    udma_sync2 #(.W(2)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw_in),
        .q_o   (sync_out)
    );

    udma_fall_det u_fall (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .lvl_i  (strobe_s),
        .fall_o (strobe_fall)
    );

    udma_launch_fsm #(
        .ACK_CYC (ACK_CYC),
        .REL_CYC (REL_CYC),
        .SEL_W   (SEL_W),
        .ADDR_W  (ADDR_W)
    ) u_fsm (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .start_en_i     (start_en_i),
        .req_s_i        (req_s),
        .strobe_fall_i  (strobe_fall),
        .end_burst_i    (end_burst_i),
        .idle_rdy_n_i   (idle_rdy_n_i),
        .idle_sel_n_i   (idle_sel_n_i),
        .idle_addr_i    (idle_addr_i),
        .stop_o         (stop_o),
        .host_rdy_n_o   (host_rdy_n_o),
        .sel_n_o        (sel_n_o),
        .addr_o         (addr_o),
        .ack_n_o        (ack_n_o),
        .bus_drive_o    (bus_drive_o),
        .burst_active_o (burst_active_o)
    );
endmodule

// File: rtl/udma_burst_launch_chk.sv
module udma_burst_launch_chk #(
    parameter int T_ACK  = 3,
    parameter int T_AZ   = 2,
    parameter int SEL_W  = 2,
    parameter int ADDR_W = 3
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              stop_o,
    input logic              host_rdy_n_o,
    input logic [SEL_W-1:0]  sel_n_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              ack_n_o,
    input logic              bus_drive_o,
    input logic              burst_active_o
);
    logic [7:0] settle_q;
    logic [7:0] acklow_q;
    logic       parked;

    assign parked = stop_o && host_rdy_n_o && (sel_n_o == '1) && (addr_o == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            settle_q <= '0;
            acklow_q <= '0;
        end else begin
            if (!ack_n_o)                settle_q <= settle_q;
            else if (parked && settle_q != 8'hFF) settle_q <= settle_q + 1'b1;
            else if (!parked)            settle_q <= '0;
            if (ack_n_o)                 acklow_q <= '0;
            else if (acklow_q != 8'hFF)  acklow_q <= acklow_q + 1'b1;
        end
    end

    // R4
    ack_settle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ack_n_o) |-> (settle_q >= 8'(T_ACK)));

    // R5
    bus_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ack_n_o && bus_drive_o) |-> (acklow_q < 8'(T_AZ)));

    // R3
    ack_parked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !ack_n_o |-> parked);

    // R8
    sel_after_ack_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ack_n_o) |-> ((sel_n_o == '1) && (addr_o == '0) && stop_o));

    // R10
    active_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(burst_active_o) |-> $past(stop_o));
endmodule

bind udma_burst_launch udma_burst_launch_chk #(
    .T_ACK  (ACK_CYC),
    .T_AZ   (AZ_CYC),
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .stop_o         (stop_o),
    .host_rdy_n_o   (host_rdy_n_o),
    .sel_n_o        (sel_n_o),
    .addr_o         (addr_o),
    .ack_n_o        (ack_n_o),
    .bus_drive_o    (bus_drive_o),
    .burst_active_o (burst_active_o)
);

// File: tb/udma_burst_launch_test.sv
module udma_burst_launch_test;
    localparam int CLK_PER = 10;
    localparam int TACK    = 3;
    localparam int TAZ     = 3;
    localparam int REL     = 2;
    localparam int WD_CYC  = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_en = 1'b0;
    logic       dev_req = 1'b0;
    logic       dev_strobe = 1'b1;
    logic       end_burst = 1'b0;
    logic       idle_rdy_n = 1'b0;
    logic [1:0] idle_sel_n = 2'b01;
    logic [2:0] idle_addr = 3'd5;
    logic       stop, rdy_n, ack_n, drive, active;
    logic [1:0] sel_n;
    logic [2:0] addr;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PER/2) clk = ~clk;

    udma_burst_launch #(.T_ACK(TACK), .T_AZ(TAZ), .BUS_REL(REL)) uut (
        .clk_i (clk), .rst_i (rst), .start_en_i (start_en), .dev_req_i (dev_req),
        .dev_strobe_i (dev_strobe), .end_burst_i (end_burst),
        .idle_rdy_n_i (idle_rdy_n), .idle_sel_n_i (idle_sel_n), .idle_addr_i (idle_addr),
        .stop_o (stop), .host_rdy_n_o (rdy_n), .sel_n_o (sel_n), .addr_o (addr),
        .ack_n_o (ack_n), .bus_drive_o (drive), .burst_active_o (active)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_stop(output int n);
        n = 0;
        while (!stop && n < 20) begin step(1); n++; end
    endtask

    task automatic wait_ack(output int n);
        n = 0;
        while (ack_n && n < 20) begin step(1); n++; end
    endtask

    task automatic check_parked(input string req);
        chk(rdy_n == 1'b1, req, rdy_n, 1);
        chk(sel_n == 2'b11, req, sel_n, 3);
        chk(addr == 3'd0, req, addr, 0);
        chk(ack_n == 1'b1, req, ack_n, 1);
    endtask

    task automatic end_and_check;
        end_burst = 1'b1;
        step(1);
        end_burst = 1'b0;
        chk(ack_n == 1'b1, "R8 ack released", ack_n, 1);
        chk(active == 1'b0, "R10 active off", active, 0);
        chk(sel_n == 2'b11, "R8 sel still negated", sel_n, 3);
        chk(addr == 3'd0, "R8 addr still negated", addr, 0);
        step(1);
        chk(sel_n == idle_sel_n, "R8 sel restored", sel_n, idle_sel_n);
        chk(addr == idle_addr, "R8 addr restored", addr, idle_addr);
        chk(stop == 1'b0, "R8 stop off", stop, 0);
    endtask

    initial begin
        int n;
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk(ack_n == 1'b1, "R1 ack", ack_n, 1);
        chk(stop == 1'b0, "R1 stop", stop, 0);
        chk(active == 1'b0, "R1 active", active, 0);
        chk(drive == 1'b1, "R1 drive", drive, 1);
        // R1 idle pass-through sweep
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 8; a++) begin
                for (int r = 0; r < 2; r++) begin
                    idle_sel_n = 2'(s); idle_addr = 3'(a); idle_rdy_n = 1'(r);
                    #1;
                    chk(sel_n == 2'(s) && addr == 3'(a) && rdy_n == 1'(r),
                        "R1 idle pass", {sel_n, addr, rdy_n}, {2'(s), 3'(a), 1'(r)});
                end
            end
        end
        // R9 end command while idle; R2 no start without enable
        dev_req = 1'b1;
        end_burst = 1'b1;
        step(2);
        end_burst = 1'b0;
        step(6);
        chk(stop == 1'b0, "R2 R9 idle hold", stop, 0);
        chk(ack_n == 1'b1, "R9 idle ack", ack_n, 1);
        // R2 start with request already synchronized
        start_en = 1'b1;
        wait_stop(n);
        chk(n == 1, "R2 sync start latency", n, 1);
        check_parked("R3 setup cycle");
        start_en = 1'b0;
        // R9 end command during setup ignored
        end_burst = 1'b1;
        step(1);
        end_burst = 1'b0;
        wait_ack(n);
        chk(n == TACK - 1, "R4 R9 ack after early end", n, TACK - 1);
        end_and_check();
        dev_req = 1'b0;
        step(4);
        // R2 R4 R5 R6 R8 R10: end at every offset
        for (int k = 0; k < 6; k++) begin
            idle_sel_n = 2'(k % 4); idle_addr = 3'(7 - k); idle_rdy_n = 1'(k % 2);
            start_en = 1'b1;
            dev_req  = 1'b1;
            wait_stop(n);
            chk(n == 3, "R2 request latency", n, 3);
            check_parked("R3 setup cycle");
            start_en = 1'b0;
            wait_ack(n);
            chk(n == TACK, "R4 settle count", n, TACK);
            dev_req = 1'b0;
            for (int j = 0; j <= k; j++) begin
                chk(ack_n == 1'b0, "R6 ack held", ack_n, 0);
                chk(active == 1'b1, "R10 active on", active, 1);
                chk(drive == (j < REL), "R5 bus drive", drive, (j < REL));
                if (j < k) step(1);
            end
            end_and_check();
            step(3);
        end
        // R7 withdraw after strobe fall
        start_en = 1'b1;
        dev_req  = 1'b1;
        wait_stop(n);
        start_en = 1'b0;
        wait_ack(n);
        dev_strobe = 1'b0;
        step(6);
        chk(ack_n == 1'b0, "R6 strobe alone keeps ack", ack_n, 0);
        dev_req = 1'b0;
        step(2);
        chk(ack_n == 1'b0, "R7 before sync", ack_n, 0);
        step(1);
        chk(ack_n == 1'b1, "R7 withdraw ends burst", ack_n, 1);
        step(1);
        chk(sel_n == idle_sel_n, "R7 sel restored", sel_n, idle_sel_n);
        dev_strobe = 1'b1;
        step(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule